// File: doc/BRIEF.md
# Asynchronous-Host Register Bus Slave

This block lets a host processor with a strobe-based, asynchronous bus reach a 512-word, 16-bit register space that lives in a synchronous clock domain. The host drives these signals:

- an active-low address strobe;
- an active-low chip select;
- a read/write select, where high means read;
- an active-low data strobe;
- a 9-bit address;
- a shared 16-bit data bus.

Each input passes through a two-stage synchroniser. After that, strobe edges are found by comparing each synchronised level with its value one clock earlier.

The address is captured when the address strobe returns high. A falling data strobe then starts the access.

- **Write:** the bus value is captured and handed to the register file as a single write-enable pulse.
- **Read:** a single read-enable pulse goes to the register file. The registered answer from the register file is captured one clock later and then driven onto the data bus.

In both cases an active-low acknowledge tells the host it may finish. The host ends the cycle by raising the data strobe. The block then drops the acknowledge and floats the bus.

The register-side port is simple. It carries an address, a write enable with write data, and a read enable. Read data is expected one clock after the read enable.

Top module: `regbus_slave`

## Requirements
- R1: After reset the acknowledge output is high (inactive), neither register enable is active, and the block does not drive the data bus.
- R2: The address used for an access is the one on the address pins when the address strobe rose while chip select was low. Later changes on the address pins have no effect, and an address strobe that rises with chip select high leaves the latched address unchanged.
- R3: A data-strobe fall with chip select low and read/write high gives exactly one read-enable pulse at the latched address. The register's answer, which arrives one clock after that pulse, is then driven on the data bus while the acknowledge is low.
- R4: A data-strobe fall with chip select low and read/write low gives exactly one write-enable pulse. The pulse carries the latched address and the bus value present when the strobe fell, and the acknowledge follows it.
- R5: The acknowledge stays low until the data strobe returns high. Within 8 clocks after that, the acknowledge is high again and the data bus is released.
- R6: A data strobe that falls while chip select is high produces no acknowledge, no register enable and no change to any register.
- R7: Raising chip select during an acknowledged cycle returns the acknowledge high within 8 clocks. Lowering chip select again while the data strobe is still low starts no new access.
- R8: On a read the acknowledge falls exactly two clocks after the read-enable pulse. On a write it falls exactly one clock after the write-enable pulse.
- R9: Read data stays unchanged on the bus for as long as the acknowledge is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Host address strobe, active low |
| cs_n | input | 1 | Host chip select, active low |
| rw | input | 1 | Host direction, 1 = read, 0 = write |
| ds_n | input | 1 | Host data strobe, active low |
| addr | input | 9 | Host address |
| data | inout | 16 | Shared host data bus |
| dtack_n | output | 1 | Data acknowledge to host, active low |
| reg_addr | output | 9 | Register-side address |
| reg_we | output | 1 | Register write enable, one-clock pulse |
| reg_wdata | output | 16 | Register write data |
| reg_re | output | 1 | Register read enable, one-clock pulse |
| reg_rdata | input | 16 | Register read data, valid one clock after reg_re |

## Verification
A wrong latched address shows up in two places. On a write, the register-side address during the write pulse is wrong. On a read, the word returned is wrong when it is read back, and this appears within the same host cycle. A sequencer stuck in or skipping a state shows up as one of the following:

- an acknowledge that never arrives;
- an acknowledge that arrives at the wrong offset from the enable pulse;
- an acknowledge that stays low after the data strobe or chip select has risen;
- a bus that is still driven when the host tries to use it.

All of these are visible within a few clocks of the strobe edge. Every address is written and then read back, so a decoding or capture fault anywhere in the 512-word space is caught.

// File: rtl/regbus_slave.sv
module regbus_slave #(
  parameter int AW   = 9,
  parameter int DW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_n,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          ds_n,
  input  logic [AW-1:0] addr,
  inout  wire  [DW-1:0] data,
  output logic          dtack_n,
  output logic [AW-1:0] reg_addr,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_RCAP, S_ACK} st_t;

  logic [SYNC-1:0] as_sh, cs_sh, ds_sh, rw_sh;
  logic [AW-1:0]   a_sh [SYNC];
  logic [DW-1:0]   d_sh [SYNC];
  logic            as_s, cs_s, ds_s, rw_s, as_q, ds_q;
  logic            as_rise, ds_fall;
  logic [AW-1:0]   adr_q;
  logic [DW-1:0]   wdata_q, rdata_q;
  logic            is_rd;
  logic            drive;
  st_t             st;

  assign as_s = as_sh[SYNC-1];
  assign cs_s = cs_sh[SYNC-1];
  assign ds_s = ds_sh[SYNC-1];
  assign rw_s = rw_sh[SYNC-1];

  assign as_rise = as_s && !as_q;
  assign ds_fall = !ds_s && ds_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_sh <= '1;
      cs_sh <= '1;
      ds_sh <= '1;
      rw_sh <= '1;
      as_q  <= 1'b1;
      ds_q  <= 1'b1;
      for (int i = 0; i < SYNC; i++) begin
        a_sh[i] <= '0;
        d_sh[i] <= '0;
      end
    end else begin
      as_sh <= {as_sh[SYNC-2:0], as_n};
      cs_sh <= {cs_sh[SYNC-2:0], cs_n};
      ds_sh <= {ds_sh[SYNC-2:0], ds_n};
      rw_sh <= {rw_sh[SYNC-2:0], rw};
      as_q  <= as_s;
      ds_q  <= ds_s;
      a_sh[0] <= addr;
      d_sh[0] <= data;
      for (int i = 1; i < SYNC; i++) begin
        a_sh[i] <= a_sh[i-1];
        d_sh[i] <= d_sh[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      adr_q <= '0;
    else if (as_rise && !cs_s)
      adr_q <= a_sh[SYNC-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_rd   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (cs_s) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:
          if (ds_fall) begin
            is_rd <= rw_s;
            if (rw_s) begin
              st <= S_RD;
            end else begin
              wdata_q <= d_sh[SYNC-1];
              st      <= S_WR;
            end
          end
        S_WR:   st <= S_ACK;
        S_RD:   st <= S_RCAP;
        S_RCAP: begin
          rdata_q <= reg_rdata;
          st      <= S_ACK;
        end
        S_ACK:  if (ds_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign drive     = (st == S_ACK) && is_rd && !cs_s;
  assign data      = drive ? rdata_q : 'z;
  assign dtack_n   = !((st == S_ACK) && !cs_s);
  assign reg_we    = (st == S_WR);
  assign reg_re    = (st == S_RD);
  assign reg_addr  = adr_q;
  assign reg_wdata = wdata_q;

endmodule

// File: rtl/regbus_slave_chk.sv
module regbus_slave_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dtack_n,
  input logic          reg_we,
  input logic          reg_re,
  input logic          drive,
  input logic          ds_s,
  input logic          cs_s,
  input logic [DW-1:0] data
);

  // R4
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R3
  re_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  // R8
  ack_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> ($past(reg_we) || $past(reg_re, 2)));

  // R5
  ack_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_n) |-> (cs_s || $past(ds_s) || $past(cs_s)));

  // R9
  read_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && !dtack_n && !$past(dtack_n)) |-> $stable(data));

endmodule

bind regbus_slave regbus_slave_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dtack_n (dtack_n),
  .reg_we  (reg_we),
  .reg_re  (reg_re),
  .drive   (drive),
  .ds_s    (ds_s),
  .cs_s    (cs_s),
  .data    (data)
);

// File: tb/sim_regbus_slave.sv
module sim_regbus_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        as_n = 1'b1, cs_n = 1'b1, rw = 1'b1, ds_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] host_d = '0;
  logic        host_oe = 1'b0;
  wire  [15:0] bus;
  logic        dtack_n, reg_we, reg_re;
  logic [8:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [15:0] mem [512];
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  assign bus = host_oe ? host_d : 'z;

  regbus_slave u0 (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_n(cs_n), .rw(rw), .ds_n(ds_n),
    .addr(addr), .data(bus), .dtack_n(dtack_n), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_re) reg_rdata <= mem[reg_addr];
  end

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 2654) ^ 16'h5A3C) + 16'(a);
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic latch_addr(input logic [8:0] a, input logic csl);
    @(negedge clk);
    as_n = 1'b0; addr = a; cs_n = !csl;
    repeat (3) @(negedge clk);
    as_n = 1'b1;
    repeat (3) @(negedge clk);
    addr = ~a;
  endtask

  task automatic release_chk(input string r);
    bit up = 1'b0;
    ds_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (dtack_n) begin up = 1'b1; break; end
    end
    chk(up, r, dtack_n, 1);
    cs_n = 1'b1;
    host_oe = 1'b1; host_d = 16'hA5C3;
    @(negedge clk);
    chk(bus == 16'hA5C3, r, bus, 16'hA5C3);
    host_oe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_write(input logic [8:0] a, input logic [15:0] d);
    int we_n = 0, we_i = 0, ack_i = 0;
    logic [8:0] wa = '0;
    logic [15:0] wd = '0;
    latch_addr(a, 1'b1);
    rw = 1'b0; host_d = d; host_oe = 1'b1;
    @(negedge clk);
    ds_n = 1'b0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (reg_we) begin we_n++; we_i = i; wa = reg_addr; wd = reg_wdata; end
      if (reg_re) we_n += 100;
      if (!dtack_n) begin ack_i = i; break; end
    end
    host_oe = 1'b0;
    chk(we_n == 1, "R4 write pulse count", we_n, 1);
    chk(wa == a, "R2 latched write address", wa, a);
    chk(wd == d, "R4 write data", wd, d);
    chk(ack_i - we_i == 1, "R8 write ack offset", ack_i - we_i, 1);
    release_chk("R5 release after write");
  endtask

  task automatic host_read(input logic [8:0] a, input logic [15:0] exp);
    int re_n = 0, re_i = 0, ack_i = 0;
    logic [15:0] v = '0, v2 = '0;
    latch_addr(a, 1'b1);
    rw = 1'b1;
    @(negedge clk);
    ds_n = 1'b0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (reg_re) begin re_n++; re_i = i; end
      if (reg_we) re_n += 100;
      if (!dtack_n) begin ack_i = i; v = bus; break; end
    end
    @(negedge clk);
    v2 = bus;
    chk(re_n == 1, "R3 read pulse count", re_n, 1);
    chk(v == exp, "R3 read data", v, exp);
    chk(v2 == exp && !dtack_n, "R9 read data held", v2, exp);
    chk(ack_i - re_i == 2, "R8 read ack offset", ack_i - re_i, 2);
    release_chk("R5 release after read");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    reg_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(dtack_n && !reg_we && !reg_re, "R1 idle outputs", {dtack_n, reg_we, reg_re}, 3'b100);
    host_oe = 1'b1; host_d = 16'h1234;
    @(negedge clk);
    chk(bus == 16'h1234, "R1 bus released", bus, 16'h1234);
    host_oe = 1'b0;

    for (int a = 0; a < 512; a++) host_write(9'(a), pat(a));

    // R6: address strobe and data strobe with chip select high
    host_read(9'd7, pat(7));
    begin
      int ev = 0;
      latch_addr(9'd5, 1'b0);
      rw = 1'b0; host_oe = 1'b1; host_d = 16'hDEAD;
      @(negedge clk);
      ds_n = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!dtack_n || reg_we || reg_re) ev++;
      end
      chk(ev == 0, "R6 strobe without select", ev, 0);
      chk(reg_addr == 9'd7, "R2 latch needs select", reg_addr, 7);
      ds_n = 1'b1; host_oe = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R7: drop select mid-acknowledge, reselect with strobe still low
    begin
      int ev = 0;
      bit up = 1'b0;
      bit acked = 1'b0;
      latch_addr(9'd9, 1'b1);
      rw = 1'b0; host_oe = 1'b1; host_d = pat(9);
      @(negedge clk);
      ds_n = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!dtack_n) begin acked = 1'b1; break; end
      end
      chk(acked, "R7 ack before deselect", dtack_n, 0);
      cs_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (dtack_n) begin up = 1'b1; break; end
      end
      chk(up, "R7 ack drops on deselect", dtack_n, 1);
      repeat (4) @(negedge clk);
      cs_n = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!dtack_n || reg_we || reg_re) ev++;
      end
      chk(ev == 0, "R7 no restart without new strobe", ev, 0);
      ds_n = 1'b1; cs_n = 1'b1; host_oe = 1'b0;
      repeat (4) @(negedge clk);
    end

    for (int a = 0; a < 512; a++) host_read(9'(a), pat(a));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule